// File: doc/BRIEF.md
# Clock Generator Power-Up Sequencer with One-Shot Strap Capture

This controller brings a clock generator from power-off to normal running. Once the supply-ok flag is high it waits a settling time and then starts watching an active-low power-good input. The first qualified low on power-good captures the five frequency-select strap pins into a status register. A stabilisation wait follows, after which the output-enable flag rises and stays high.

The capture is one-shot. After it, further edges on power-good or on the strap pins change nothing until the supply-ok flag drops. That drop returns the controller to power-off and releases the lock. The effective frequency code is chosen continuously. With the override bit clear it is the captured strap value. With the bit set it is a 5-bit software field. The captured value is also brought out so it can be read as bits 4:0 of a control register.

The states are `ST_OFF` (supply absent), `ST_SETTLE` (settling delay), `ST_ARMED` (waiting for power-good), `ST_HOLD` (straps captured, waiting for stability) and `ST_RUN` (outputs enabled). The transitions are:
- `OFF→SETTLE` when supply-ok is seen.
- `SETTLE→ARMED` when the settling count expires.
- `ARMED→HOLD` on a qualified power-good low, which also captures the straps.
- `HOLD→RUN` when the stabilisation count expires.
- `any→OFF` when supply-ok falls.

Top module: `clkgen_pwrup_ctrl`

## Requirements
- R1: After reset, `out_en` is 0 and `strap_status` is 5'b00000.
- R2: When `supply_ok` is low at a clock edge, `out_en` is 0 and `strap_status` is 0 after that edge. The lock is released, so the next power-up captures the strap pins anew.
- R3: Power-good is not acted on during the `SETTLE_CYC` cycles that follow `supply_ok` rising. If `pgood_n` is already low, `out_en` first reads 1 after the (SETTLE_CYC+STABLE_CYC+2)-th rising edge, counting the first edge that sees `supply_ok` high as edge 1. Until capture, `strap_status` stays 0.
- R4: `pgood_n` passes through a two-flop synchroniser. It counts as low only when two consecutive synchronised samples are low, so a low lasting one clock cycle causes no capture.
- R5: In `ST_ARMED`, `pgood_n` may go low ahead of rising edge 1. `out_en` then first reads 1 after rising edge STABLE_CYC+4. From then on, `strap_status` equals the value `strap` held at that time, with bit i of `strap_status` taken from `strap[i]`.
- R6: Once the straps are captured, changes on `pgood_n` and `strap` have no effect on `strap_status` or `out_en` while `supply_ok` stays high.
- R7: `eff_code` equals `strap_status` when `fs_override` is 0 and equals `sw_code` when it is 1. The selection is combinational.
- R8: `out_en` is 1 only in `ST_RUN`. It stays 1 for as long as `supply_ok` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply-good flag, synchronous to clk |
| pgood_n | input | 1 | Active-low power-good, asynchronous |
| strap | input | 5 | Frequency-select strap pins |
| fs_override | input | 1 | 1 selects the software code, 0 the captured straps |
| sw_code | input | 5 | Software frequency code |
| strap_status | output | 5 | Captured strap value, 0 before capture |
| eff_code | output | 5 | Effective frequency select code |
| out_en | output | 1 | Clock output enable |

## Verification
The hardest situation to reach from the ports is one where the one-shot lock has been released and must take a fresh capture. The supply has to drop in the middle of a sequence, and the next power-up must record a strap value different from the first. The stimulus runs every one of the 32 strap values through a full power cycle. After each capture it inverts the straps and toggles power-good. The supply is also cut during the stabilisation wait and again while running, and the bench then checks that a new value is captured. Two further cases target the qualifier and the settling window: a single-cycle power-good pulse, and power-good held low before the supply rises.

// File: rtl/clkgen_pwrup_pkg.sv
package clkgen_pwrup_pkg;

    typedef enum logic [2:0] {
        ST_OFF    = 3'd0,
        ST_SETTLE = 3'd1,
        ST_ARMED  = 3'd2,
        ST_HOLD   = 3'd3,
        ST_RUN    = 3'd4
    } pwr_state_t;

endpackage

// File: rtl/pg_qualifier.sv
module pg_qualifier (
    input  logic clk,
    input  logic rst_n,
    input  logic pgood_n,
    output logic pg_valid
);
    logic sync1, sync2, hist;

    // two-stage synchroniser plus one history stage for the double-low rule
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1 <= 1'b1;
            sync2 <= 1'b1;
            hist  <= 1'b1;
        end else begin
            sync1 <= pgood_n;
            sync2 <= sync1;
            hist  <= sync2;
        end
    end

    assign pg_valid = !sync2 && !hist;
endmodule

// File: rtl/phase_timer.sv
module phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt <= '0;
        else if (clear)  cnt <= '0;
        else if (!done)  cnt <= cnt + 1'b1;
    end

    assign done = (cnt == limit - 1'b1);
endmodule

// File: rtl/strap_select.sv
module strap_select #(
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              capture,
    input  logic [CODE_W-1:0] strap,
    input  logic              fs_override,
    input  logic [CODE_W-1:0] sw_code,
    output logic [CODE_W-1:0] strap_q,
    output logic [CODE_W-1:0] eff_code
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       strap_q <= '0;
        else if (clr)     strap_q <= '0;
        else if (capture) strap_q <= strap;
    end

    assign eff_code = fs_override ? sw_code : strap_q;
endmodule

// File: rtl/clkgen_pwrup_ctrl.sv
module clkgen_pwrup_ctrl
    import clkgen_pwrup_pkg::*;
#(
    parameter int CODE_W     = 5,
    parameter int SETTLE_CYC = 50000,
    parameter int STABLE_CYC = 229200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              supply_ok,
    input  logic              pgood_n,
    input  logic [CODE_W-1:0] strap,
    input  logic              fs_override,
    input  logic [CODE_W-1:0] sw_code,
    output logic [CODE_W-1:0] strap_status,
    output logic [CODE_W-1:0] eff_code,
    output logic              out_en
);
    localparam int MAX_CYC = (SETTLE_CYC > STABLE_CYC) ? SETTLE_CYC : STABLE_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    pwr_state_t       state, state_nx;
    logic             pg_valid;
    logic             tmr_done, tmr_clear;
    logic [CNT_W-1:0] tmr_limit;
    logic             capture;

    pg_qualifier i_pgq (
        .clk      (clk),
        .rst_n    (rst_n),
        .pgood_n  (pgood_n),
        .pg_valid (pg_valid)
    );

    assign tmr_limit = (state == ST_HOLD) ? CNT_W'(STABLE_CYC) : CNT_W'(SETTLE_CYC);
    assign tmr_clear = (state != state_nx) || !((state == ST_SETTLE) || (state == ST_HOLD));

    phase_timer #(.CNT_W(CNT_W)) i_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (tmr_clear),
        .limit (tmr_limit),
        .done  (tmr_done)
    );

    assign capture = supply_ok && (state == ST_ARMED) && pg_valid;

    strap_select #(.CODE_W(CODE_W)) i_sel (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (!supply_ok),
        .capture     (capture),
        .strap       (strap),
        .fs_override (fs_override),
        .sw_code     (sw_code),
        .strap_q     (strap_status),
        .eff_code    (eff_code)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        if (!supply_ok) begin
            state_nx = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF:    state_nx = ST_SETTLE;
                ST_SETTLE: if (tmr_done) state_nx = ST_ARMED;
                ST_ARMED:  if (pg_valid) state_nx = ST_HOLD;
                ST_HOLD:   if (tmr_done) state_nx = ST_RUN;
                ST_RUN:    state_nx = ST_RUN;
                default:   state_nx = ST_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    // outputs
    always_comb begin
        out_en = (state == ST_RUN);
    end
endmodule

// File: rtl/clkgen_pwrup_chk.sv
module clkgen_pwrup_chk
    import clkgen_pwrup_pkg::*;
#(
    parameter int CODE_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              supply_ok,
    input logic              fs_override,
    input logic [CODE_W-1:0] sw_code,
    input logic [CODE_W-1:0] strap_status,
    input logic [CODE_W-1:0] eff_code,
    input logic              out_en,
    input pwr_state_t        st
);
    AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (!out_en && strap_status == '0)); // R2

    AST_LOCK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en && supply_ok) |=> $stable(strap_status)); // R6

    AST_EN_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_en) |-> ($past(st) == ST_HOLD)); // R5

    AST_EN_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en && supply_ok) |=> out_en); // R8

    AST_NO_CAPTURE_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SETTLE) |-> (strap_status == '0)); // R3

    AST_SEL_SW: assert property (@(posedge clk) disable iff (!rst_n)
        fs_override |-> (eff_code == sw_code)); // R7

    AST_SEL_STRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !fs_override |-> (eff_code == strap_status)); // R7
endmodule

bind clkgen_pwrup_ctrl clkgen_pwrup_chk #(.CODE_W(CODE_W)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .supply_ok    (supply_ok),
    .fs_override  (fs_override),
    .sw_code      (sw_code),
    .strap_status (strap_status),
    .eff_code     (eff_code),
    .out_en       (out_en),
    .st           (state)
);

// File: tb/test_clkgen_pwrup_ctrl.sv
`timescale 1ns/1ps
module test_clkgen_pwrup_ctrl;
    localparam int S = 4;
    localparam int T = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       supply_ok = 1'b0;
    logic       pgood_n = 1'b1;
    logic [4:0] strap = '0;
    logic       fs_override = 1'b0;
    logic [4:0] sw_code = '0;
    logic [4:0] strap_status, eff_code;
    logic       out_en;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    clkgen_pwrup_ctrl #(.CODE_W(5), .SETTLE_CYC(S), .STABLE_CYC(T)) i_clkgen_pwrup_ctrl (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .pgood_n(pgood_n),
        .strap(strap), .fs_override(fs_override), .sw_code(sw_code),
        .strap_status(strap_status), .eff_code(eff_code), .out_en(out_en)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_en(input int lim, output int n);
        n = 0;
        while (n < lim) begin
            @(negedge clk);
            n++;
            if (out_en) break;
        end
    endtask

    task automatic power_cut();
        supply_ok = 1'b0;
        pgood_n = 1'b1;
        step(1);
        chk("R2 out_en after drop", int'(out_en), 0);
        chk("R2 status after drop", int'(strap_status), 0);
        step(3);
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int n;
        step(3);
        chk("R1 out_en in reset", int'(out_en), 0);
        chk("R1 status in reset", int'(strap_status), 0);
        rst_n = 1'b1;
        step(2);
        chk("R1 out_en after reset", int'(out_en), 0);
        chk("R1 status after reset", int'(strap_status), 0);

        // sweep of all strap values
        for (int v = 0; v < 32; v++) begin
            strap = 5'(v);
            supply_ok = 1'b1;
            step(S + 2);
            chk("R3 no capture while armed high", int'(strap_status), 0);
            chk("R8 out_en low before run", int'(out_en), 0);
            pgood_n = 1'b0;
            wait_en(40, n);
            chk("R5 latency pgood to out_en", n, T + 4);
            chk("R5 captured value", int'(strap_status), v);
            strap = ~5'(v);
            pgood_n = 1'b1;
            step(3);
            pgood_n = 1'b0;
            step(3);
            chk("R6 status after toggles", int'(strap_status), v);
            chk("R6 out_en after toggles", int'(out_en), 1);
            fs_override = 1'b0;
            sw_code = 5'(v) ^ 5'h15;
            #0.1;
            chk("R7 strap path", int'(eff_code), v);
            fs_override = 1'b1;
            #0.1;
            chk("R7 software path", int'(eff_code), int'(5'(v) ^ 5'h15));
            fs_override = 1'b0;
            power_cut();
        end

        // single-cycle power-good pulse is ignored
        strap = 5'h0b;
        supply_ok = 1'b1;
        step(S + 3);
        pgood_n = 1'b0;
        step(1);
        pgood_n = 1'b1;
        step(T + 10);
        chk("R4 no capture from 1-cycle pulse", int'(strap_status), 0);
        chk("R4 out_en stays low", int'(out_en), 0);
        pgood_n = 1'b0;
        wait_en(40, n);
        chk("R4 later real low still works", n, T + 4);
        chk("R4 captured value", int'(strap_status), 11);
        power_cut();

        // power-good low before supply rises
        strap = 5'h1c;
        pgood_n = 1'b0;
        step(4);
        supply_ok = 1'b1;
        step(S);
        chk("R3 status zero during settle", int'(strap_status), 0);
        wait_en(40, n);
        chk("R3 latency from supply", n + S, S + T + 2);
        chk("R3 captured value", int'(strap_status), 28);

        // out_en holds over a long run
        for (int k = 0; k < 20; k++) begin
            step(1);
            chk("R8 out_en held", int'(out_en), 1);
        end
        power_cut();

        // drop during hold, then recapture a new value
        strap = 5'h05;
        supply_ok = 1'b1;
        step(S + 3);
        pgood_n = 1'b0;
        step(5);
        chk("R5 status captured in hold", int'(strap_status), 5);
        chk("R8 out_en low in hold", int'(out_en), 0);
        power_cut();
        strap = 5'h1a;
        supply_ok = 1'b1;
        step(S + 3);
        pgood_n = 1'b0;
        wait_en(40, n);
        chk("R2 relock latency", n, T + 4);
        chk("R2 relock new value", int'(strap_status), 26);
        power_cut();

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule